// File: doc/BRIEF.md
# Packed-control event monitor

This block counts hardware events for software that profiles a processor or a subsystem. It holds three 32-bit counters: one that follows the clock and two that count event pulses. Each event counter picks its event source through an 8-bit code. All configuration lives in one 32-bit control word. That word carries the global enable, two reset strobes, a divide-by-64 option for the clock counter, three interrupt enables, three sticky overflow flags and both event selectors.

Software uses a plain addressed register bus with a write strobe and a combinational read port. The address map is 0 for the control word, 1 for the clock counter, 2 for event counter 0 and 3 for event counter 1. Event sources drive a vector of single-cycle pulses. Bit k of that vector is the event whose code is k. A level interrupt reports any enabled overflow until software acknowledges it. To acknowledge, software writes the control word back with the flag bits it read. The bus and the event vector are plain control and status pins. Nothing at the edge of this block streams, so it has no valid/ready handshake and no back-pressure.

Top module: `evmon_top`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low.
- R2: In the control word, bits 1, 2, 7, 11 and 28 to 31 always read back as 0, whatever value was written to them.
- R3: While control bit 0 (enable) is 0, no counter advances and the divide-by-64 prescaler does not advance. Counter values and flags are kept.
- R4: While enabled with control bit 3 clear, the clock counter advances by one on every clock. With bit 3 set, it advances once per 64 enabled clocks. The first advance comes on the 64th such clock after the prescaler was last zeroed.
- R5: Event counter 0 takes its code from control bits 12 to 19, and event counter 1 takes its code from bits 20 to 27. A counter advances by one on each enabled clock in which `evt_pulse[code]` is high. Only the codes 0x00 to 0x0D, 0x10 to 0x12 and 0x14 to 0x16 count. Every other code, including 0xFF, counts nothing.
- R6: Writing the control word with bit 1 set zeroes both event counters. Writing it with bit 2 set zeroes the clock counter and the prescaler. Both bits act only in the cycle of the write.
- R7: A bus write to a counter loads that counter. The load takes priority over an increment in the same cycle.
- R8: When a counter wraps from 0xFFFFFFFF to 0, its flag is set. The flags are bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the clock counter. A flag stays set until it is cleared, and a wrap on one counter never changes the flag of another counter.
- R9: Writing a 1 to a flag bit clears that flag, and writing a 0 leaves it unchanged. If a wrap of that counter falls in the same cycle as the clear, the flag stays set.
- R10: `irq` is high exactly when some flag is set together with its enable. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the clock counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address: 0 control, 1 clock counter, 2 event counter 0, 3 event counter 1 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_pulse | input | 23 | Event pulses; bit k is the event with code k |
| irq | output | 1 | Level interrupt |

## Verification
Two kinds of cycle collide here. A flag clear and a wrap of the same counter can land in one clock, and so can a bus load and a counter increment. The bench provokes both. It preloads a counter to 0xFFFFFFFF and then, in the very next cycle, writes the control word with that flag's clear bit while events keep arriving. It also writes an event counter while its event pulses every clock. A behavioural model gives each cycle its outcome: the flag survives the clear, and the load wins over the increment. On every clock the bench reads all four registers and `irq` and compares them with that model.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int CNT_W   = 32;
  localparam int SEL_W   = 8;
  localparam int NUM_EVT = 23;
  localparam int PRE_W   = 6;
  localparam int NUM_EVC = 2;
  localparam int NUM_CNT = NUM_EVC + 1;   // index NUM_EVC is the clock counter

  // control word layout
  localparam int B_EN   = 0;
  localparam int B_ERST = 1;
  localparam int B_CRST = 2;
  localparam int B_DIV  = 3;
  localparam int B_IEN  = 4;
  localparam int B_OVF  = 8;
  localparam int B_SEL  = 12;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CYC  = 2'd1;
  localparam logic [1:0] A_EV0  = 2'd2;

  function automatic logic code_counts(input logic [SEL_W-1:0] c);
    return (c <= 8'h0D) || (c >= 8'h10 && c <= 8'h12) || (c >= 8'h14 && c <= 8'h16);
  endfunction
endpackage

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (ld)   q <= ld_val;
    else if (clr)  q <= '0;
    else if (inc)  q <= q + 1'b1;
  end

  assign wrap = inc && !ld && !clr && (&q);

  // R7: a load wins over everything else
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(ld_val));
  // R6: a strobe zeroes the counter
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !ld |=> q == '0);
  // R3: no activity means no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !ld && !clr |=> $stable(q));
endmodule

// File: rtl/evmon_prescale.sv
module evmon_prescale #(
  parameter int PW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (run)  cnt <= cnt + 1'b1;
  end

  assign tick = run && (&cnt);

  // R3: the prescaler freezes while not running
  a_r3_pre_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !clr |=> $stable(cnt));
endmodule

// File: rtl/evmon_evsel.sv
module evmon_evsel
  import evmon_pkg::*;
(
  input  logic               en,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] evt,
  output logic               hit
);
  logic [NUM_EVT-1:0] match;

  genvar k;
  generate
    for (k = 0; k < NUM_EVT; k++) begin : g_code
      localparam logic [SEL_W-1:0] CODE = SEL_W'(k);
      assign match[k] = (sel == CODE) && code_counts(CODE);
    end
  endgenerate

  assign hit = en && (|(match & evt));
endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [CNT_W-1:0]     wdata,
  input  logic [NUM_CNT-1:0]   wrap,
  output logic                 en,
  output logic                 div,
  output logic [NUM_CNT-1:0]   ien,
  output logic [NUM_CNT-1:0]   flags,
  output logic [SEL_W-1:0]     sel [NUM_EVC],
  output logic                 ev_rst,
  output logic                 cyc_rst,
  output logic [CNT_W-1:0]     word
);
  logic [NUM_CNT-1:0] clr_req;
  logic               unused_wz;

  assign unused_wz = ^{wdata[7], wdata[11], wdata[CNT_W-1:B_SEL+NUM_EVC*SEL_W]};
  assign clr_req   = wr ? wdata[B_OVF +: NUM_CNT] : '0;
  assign ev_rst    = wr && wdata[B_ERST];
  assign cyc_rst   = wr && wdata[B_CRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      div <= 1'b0;
      ien <= '0;
    end else if (wr) begin
      en  <= wdata[B_EN];
      div <= wdata[B_DIV];
      ien <= wdata[B_IEN +: NUM_CNT];
    end
  end

  genvar i;
  generate
    for (i = 0; i < NUM_EVC; i++) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sel[i] <= '0;
        else if (wr) sel[i] <= wdata[B_SEL + i*SEL_W +: SEL_W];
      end
    end
    for (i = 0; i < NUM_CNT; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flags[i] <= 1'b0;
        else if (wrap[i])    flags[i] <= 1'b1;
        else if (clr_req[i]) flags[i] <= 1'b0;
      end
      // R8: a wrap leaves its flag set
      a_r8_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[i] |=> flags[i]);
      // R9: a flag only drops when a 1 is written to it
      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flags[i] && !clr_req[i] |=> flags[i]);
      // R9: clear without a concurrent wrap drops the flag
      a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req[i] && !wrap[i] |=> !flags[i]);
    end
  endgenerate

  always_comb begin
    word = '0;
    word[B_EN]  = en;
    word[B_DIV] = div;
    word[B_IEN +: NUM_CNT] = ien;
    word[B_OVF +: NUM_CNT] = flags;
    for (int j = 0; j < NUM_EVC; j++) word[B_SEL + j*SEL_W +: SEL_W] = sel[j];
  end
endmodule

// File: rtl/evmon_top.sv
module evmon_top
  import evmon_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [1:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic               irq
);
  logic               en, div, ev_rst, cyc_rst, pre_tick, wr_ctrl;
  logic [NUM_CNT-1:0] ien, flags, wrap;
  logic [SEL_W-1:0]   sel [NUM_EVC];
  logic [CNT_W-1:0]   word;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);

  evmon_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(bus_wdata), .wrap(wrap),
    .en(en), .div(div), .ien(ien), .flags(flags), .sel(sel),
    .ev_rst(ev_rst), .cyc_rst(cyc_rst), .word(word)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_EVC; i++) begin : g_ev
      localparam logic [1:0] MY_ADDR = A_EV0 + 2'(i);
      logic hit;
      evmon_evsel u_sel (.en(en), .sel(sel[i]), .evt(evt_pulse), .hit(hit));
      evmon_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(hit), .clr(ev_rst),
        .ld(bus_we && bus_addr == MY_ADDR), .ld_val(bus_wdata),
        .q(cnt_q[i]), .wrap(wrap[i])
      );
    end
  endgenerate

  evmon_prescale #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(en && div), .clr(cyc_rst), .tick(pre_tick)
  );

  evmon_counter #(.W(CNT_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .inc(en && (div ? pre_tick : 1'b1)), .clr(cyc_rst),
    .ld(bus_we && bus_addr == A_CYC), .ld_val(bus_wdata),
    .q(cnt_q[NUM_EVC]), .wrap(wrap[NUM_EVC])
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = word;
      A_CYC:   bus_rdata = cnt_q[NUM_EVC];
      A_EV0:   bus_rdata = cnt_q[0];
      default: bus_rdata = cnt_q[1];
    endcase
  end

  assign irq = |(flags & ien);

  // R10: irq cannot rise without a flag that was already pending
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (flags != '0));
  // R2: write-as-zero positions in the readback
  a_r2_wz_bits: assert property (@(posedge clk) disable iff (!rst_n)
    word[31:28] == 4'h0 && !word[11] && !word[7] && !word[2] && !word[1]);
endmodule

// File: tb/sim_evmon_top.sv
`timescale 1ns/1ps
module sim_evmon_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [22:0] evt_pulse = '0;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  string       cur_req = "R1";

  // behavioural reference state
  logic [31:0] m_cyc = '0, m_e0 = '0, m_e1 = '0;
  bit          m_en = 0, m_div = 0;
  logic [2:0]  m_ien = '0, m_flg = '0;   // index 0 ev0, 1 ev1, 2 clock
  logic [7:0]  m_s0 = '0, m_s1 = '0;
  int          m_pre = 0;

  evmon_top u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq(irq));

  always #2 clk = ~clk;   // 250 MHz

  function automatic bit counts(input logic [7:0] c);
    return (c <= 8'h0D) || (c >= 8'h10 && c <= 8'h12) || (c >= 8'h14 && c <= 8'h16);
  endfunction

  function automatic logic [31:0] m_read(input int a);
    case (a)
      0: return {4'h0, m_s1, m_s0, 1'b0, m_flg, 1'b0, m_ien, m_div, 2'b00, m_en};
      1: return m_cyc;
      2: return m_e0;
      default: return m_e1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = '0; m_e0 = '0; m_e1 = '0; m_en = 0; m_div = 0;
      m_ien = '0; m_flg = '0; m_s0 = '0; m_s1 = '0; m_pre = 0;
    end else begin
      bit w0, tick, h0, h1;
      logic [2:0] wr;
      w0   = bus_we && bus_addr == 0;
      tick = m_en && (!m_div || m_pre == 63);
      h0   = m_en && counts(m_s0) && evt_pulse[m_s0[4:0]];
      h1   = m_en && counts(m_s1) && evt_pulse[m_s1[4:0]];
      wr   = '0;
      if (bus_we && bus_addr == 2) m_e0 = bus_wdata;
      else if (w0 && bus_wdata[1]) m_e0 = '0;
      else if (h0) begin if (m_e0 == 32'hFFFFFFFF) wr[0] = 1; m_e0++; end
      if (bus_we && bus_addr == 3) m_e1 = bus_wdata;
      else if (w0 && bus_wdata[1]) m_e1 = '0;
      else if (h1) begin if (m_e1 == 32'hFFFFFFFF) wr[1] = 1; m_e1++; end
      if (bus_we && bus_addr == 1) m_cyc = bus_wdata;
      else if (w0 && bus_wdata[2]) m_cyc = '0;
      else if (tick) begin if (m_cyc == 32'hFFFFFFFF) wr[2] = 1; m_cyc++; end
      if (w0 && bus_wdata[2]) m_pre = 0;
      else if (m_en && m_div) m_pre = (m_pre + 1) % 64;
      if (w0) m_flg = m_flg & ~bus_wdata[10:8];
      m_flg = m_flg | wr;
      if (w0) begin
        m_en = bus_wdata[0]; m_div = bus_wdata[3]; m_ien = bus_wdata[6:4];
        m_s0 = bus_wdata[19:12]; m_s1 = bus_wdata[27:20];
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", cur_req, what, act, exp);
    end
  endtask

  // one clock: compare all state in the low phase, then drive the next stimulus
  task automatic step(input bit we, input logic [1:0] a, input logic [31:0] d, input logic [22:0] ev);
    @(negedge clk);
    bus_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      bus_addr = 2'(k);
      #0.2;
      chk($sformatf("reg%0d", k), bus_rdata, m_read(k));
    end
    chk("irq", {31'd0, irq}, {31'd0, |(m_flg & m_ien)});
    bus_we = we; bus_addr = a; bus_wdata = d; evt_pulse = ev;
  endtask

  task automatic idle(input int n, input int mode);
    for (int k = 0; k < n; k++)
      step(0, 0, 0, mode == 0 ? 23'd0 : mode == 1 ? '1 : 23'($urandom));
  endtask

  function automatic logic [31:0] cw(bit en, bit div, logic [2:0] ie, logic [7:0] s0, logic [7:0] s1,
                                     logic [2:0] clr, bit er, bit cr);
    return {4'h0, s1, s0, 1'b0, clr, 1'b0, ie, div, cr, er, en};
  endfunction

  initial begin
    #(4.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    cur_req = "R1"; idle(2, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3, 0);
    // R2: all-ones write, write-as-zero bits read 0
    cur_req = "R2"; step(1, 0, 32'hFFFFFFFF, '0); idle(3, 1);
    step(1, 0, 32'h0000_0700, '0); idle(1, 0);
    // R4: plain then divided clock counting
    cur_req = "R4"; step(1, 0, cw(1, 0, 0, 8'h07, 8'h16, 0, 0, 1), '0); idle(20, 2);
    step(1, 0, cw(1, 1, 0, 8'h07, 8'h16, 0, 0, 1), '0); idle(140, 2);
    // R3: disabled with pulses, prescaler frozen mid-way, then resumed
    cur_req = "R3"; idle(30, 2);
    step(1, 0, cw(0, 1, 0, 8'h07, 8'h16, 0, 0, 0), '0); idle(30, 1);
    step(1, 0, cw(1, 1, 0, 8'h07, 8'h16, 0, 0, 0), '0); idle(80, 0);
    // R5: non-counting codes and other valid codes
    cur_req = "R5"; step(1, 0, cw(1, 0, 0, 8'h0E, 8'hFF, 0, 0, 0), '0); idle(20, 1);
    step(1, 0, cw(1, 0, 0, 8'h13, 8'h10, 0, 0, 0), '0); idle(30, 2);
    step(1, 0, cw(1, 0, 0, 8'h0D, 8'h14, 0, 0, 0), '0); idle(30, 2);
    // R6: strobes
    cur_req = "R6"; step(1, 0, cw(1, 0, 0, 8'h00, 8'h01, 0, 1, 0), '1); idle(5, 1);
    step(1, 0, cw(1, 0, 0, 8'h00, 8'h01, 0, 0, 1), '1); idle(5, 1);
    // R7: load while the counter increments every clock
    cur_req = "R7"; step(1, 2, 32'h0000_0100, '1); step(1, 3, 32'h1234_5678, '1);
    step(1, 1, 32'h0000_0042, '1); idle(4, 1);
    // R8: wraps on all three counters, each with its enable
    cur_req = "R8"; step(1, 0, cw(1, 0, 3'b111, 8'h00, 8'h01, 0, 0, 0), '0);
    step(1, 1, 32'hFFFF_FFFD, '0); step(1, 2, 32'hFFFF_FFFE, '0); step(1, 3, 32'hFFFF_FFF0, '0);
    idle(6, 1);
    // R9: partial clear, then clear in the same cycle as a wrap
    cur_req = "R9"; step(1, 0, cw(1, 0, 3'b111, 8'h00, 8'h01, 3'b001, 0, 0), '0); idle(2, 0);
    step(1, 3, 32'hFFFF_FFFF, '0);
    step(1, 0, cw(1, 0, 3'b111, 8'h00, 8'h01, 3'b010, 0, 0), '1); idle(2, 0);
    // R10: flag pending with its enable off, then on, then clear all
    cur_req = "R10"; step(1, 0, cw(1, 0, 3'b000, 8'h00, 8'h01, 0, 0, 0), '0); idle(2, 0);
    step(1, 0, cw(1, 0, 3'b010, 8'h00, 8'h01, 0, 0, 0), '0); idle(2, 0);
    step(1, 0, cw(0, 0, 3'b111, 8'h00, 8'h01, 3'b111, 0, 0), '0); idle(3, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule